// File: doc/BRIEF.md
# Serial Real-Time-Clock and NVRAM Slave

This block is the slave side of a three-wire serial link to a small real-time-clock device. A host drives a chip enable, a serial clock and a data line. While the enable is high, each falling edge of the serial clock moves one bit, most significant bit first. The first eight bits form a command byte. The next eight bits either carry a data byte into the block or carry a read byte out on the data return line. A 16-bit frame reaches one of the following by its command code:
- a 32-byte non-volatile RAM, for read or write;
- packed-BCD time registers;
- a status register and a control register;
- a write that clears the power-fail flag.

The serial pins are sampled in the system clock domain, which is the synchronous host side. The bidirectional pad is split into an input, an output and an output enable, and the pad cell joins them outside the block. The time registers capture an external binary time value on a load strobe. There is no oscillator and no calendar rollover. The RAM reset image and the control value are parameters.

Top module: `sercal_top`

## Requirements
- R1: A bit is taken only on a falling edge of `ser_clk` seen while `ser_en` is high. Bits are taken MSB first. Edges seen while `ser_en` is low have no effect.
- R2: While `ser_en` is low, the bit counter, the command byte and the data byte are cleared. A frame dropped before its 16th bit has no effect.
- R3: Commands 0x00 to 0x1F read RAM[command]. After the falling edge of bit position p (p = 8 to 15, counted from 0), `ser_dout` holds bit 7-(p-8) of the read byte, and `ser_dout_oe` is 1.
- R4: Commands 0x80 to 0x9F write the data byte into RAM[command-0x80]. The write takes place when the 16th bit is taken.
- R5: Command 0x30 reads the status register, which resets to 0x90. Command 0x31 reads the control register, which equals parameter `CTRL_INIT`.
- R6: The following commands return packed BCD, with the tens digit in bits 7:4:
  - 0x20: seconds
  - 0x21: minutes
  - 0x22: hours
  - 0x24: day
  - 0x25: month
  - 0x26: two-digit year

  Every other command from 0x20 to 0x2F returns 0x00.
- R7: The time registers capture the binary time inputs only on a cycle where `time_load` is high. Between loads, reads return the captured value.
- R8: A `pf_event` pulse sets `pf_irq` and sets status bit 3 (0x08).
- R9: Command 0xB1 with data bit 2 set clears status bits 4 and 3 (mask 0x18) and clears `pf_irq`. With data bit 2 clear, the command changes nothing.
- R10: The bit counter saturates at 16. Further falling edges are ignored until `ser_en` falls, so extra bits cannot rewrite RAM.
- R11: After reset, RAM[i] equals byte i of parameter `RAM_INIT`. The default is ((i*17) mod 256) XOR 0xA5.
- R12: Outside a read data phase, `ser_dout_oe` is 0. This covers commands with no read meaning. Both `ser_dout` and `ser_dout_oe` are 0 in the cycle after `ser_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Serial chip enable, active high |
| ser_clk | input | 1 | Serial clock; bits move on its falling edge |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial read data to host |
| ser_dout_oe | output | 1 | Drive enable for the data pad |
| time_load | input | 1 | Capture strobe for the time inputs |
| t_sec | input | TIME_W | Seconds, binary 0-59 |
| t_min | input | TIME_W | Minutes, binary 0-59 |
| t_hour | input | TIME_W | Hours, binary 0-23 |
| t_day | input | TIME_W | Day of month, binary 1-31 |
| t_mon | input | TIME_W | Month, binary 1-12 |
| t_year | input | TIME_W | Two-digit year, binary 0-99 |
| pf_event | input | 1 | Power-fail event pulse |
| pf_irq | output | 1 | Power-fail interrupt flag |

## Verification
The hardest case to reach from the ports is a frame that goes past 16 bits, or one that stops short of 16 bits. In either case the block must not commit anything. Only a later read frame can show that RAM was left alone. The stimulus uses one frame that sends eight extra bits of inverted data after a write, and another frame that drops the enable after twelve bits of a write. The bench also toggles the serial clock with the enable low, and then runs a clean frame to show that the stray edges were not counted.

// File: rtl/sercal_pkg.sv
package sercal_pkg;

  localparam int RAM_BYTES = 32;

  typedef enum logic [2:0] {
    K_NONE,
    K_RAM_RD,
    K_RAM_WR,
    K_TIME,
    K_STAT,
    K_CTRL,
    K_FLAG_CLR
  } cmd_kind_e;

  // Sort a command byte into the kind of access it requests.
  function automatic cmd_kind_e classify(input logic [7:0] c);
    if (c <= 8'h1F) return K_RAM_RD;
    if (c >= 8'h80 && c <= 8'h9F) return K_RAM_WR;
    if (c[7:4] == 4'h2) return K_TIME;
    if (c == 8'h30) return K_STAT;
    if (c == 8'h31) return K_CTRL;
    if (c == 8'hB1) return K_FLAG_CLR;
    return K_NONE;
  endfunction

  function automatic logic is_read_kind(input cmd_kind_e k);
    return (k == K_RAM_RD) || (k == K_TIME) || (k == K_STAT) || (k == K_CTRL);
  endfunction

  // Binary 0..99 into two packed BCD digits.
  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  // Default RAM image: byte i = (i*17 mod 256) ^ 0xA5.
  function automatic logic [RAM_BYTES*8-1:0] default_image();
    logic [RAM_BYTES*8-1:0] img;
    for (int i = 0; i < RAM_BYTES; i++) begin
      img[i*8 +: 8] = 8'(i * 17) ^ 8'hA5;
    end
    return img;
  endfunction

endpackage

// File: rtl/sercal_shift.sv
module sercal_shift #(
  parameter int FRAME_BITS = 16,
  localparam int HALF = FRAME_BITS / 2,
  localparam int CW   = $clog2(FRAME_BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_en,
  input  logic            ser_clk,
  input  logic            ser_din,
  output logic [CW-1:0]   bit_cnt,
  output logic [HALF-1:0] cmd,
  output logic            take,
  output logic            frame_done,
  output logic [HALF-1:0] data_final
);

  logic            sclk_q;
  logic [CW-1:0]   cnt_q;
  logic [HALF-1:0] cmd_q;
  logic [HALF-1:0] dat_q;
  logic            edge_fall;

  assign edge_fall  = sclk_q & ~ser_clk;
  assign take       = ser_en & edge_fall & (cnt_q < CW'(FRAME_BITS));
  assign frame_done = take & (cnt_q == CW'(FRAME_BITS - 1));
  assign data_final = {dat_q[HALF-2:0], ser_din};
  assign bit_cnt    = cnt_q;
  assign cmd        = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      dat_q  <= '0;
    end else begin
      sclk_q <= ser_clk;
      if (!ser_en) begin
        cnt_q <= '0;
        cmd_q <= '0;
        dat_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CW'(HALF)) cmd_q <= {cmd_q[HALF-2:0], ser_din};
        else                   dat_q <= data_final;
      end
    end
  end

  // R10: counter never runs past the frame length
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FRAME_BITS));

  // R10: a full frame stays full while enable holds
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && cnt_q == CW'(FRAME_BITS)) |=> cnt_q == CW'(FRAME_BITS));

  // R1: command byte is frozen once the data half begins
  p_cmd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && cnt_q >= CW'(HALF)) |=> $stable(cmd_q));

  // R2: enable low clears the frame state
  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> (cnt_q == '0 && cmd_q == '0 && dat_q == '0));

endmodule

// File: rtl/sercal_nvram.sv
module sercal_nvram #(
  parameter int DEPTH = 32,
  parameter logic [DEPTH*8-1:0] IMAGE = '0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= IMAGE[i*8 +: 8];
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sercal_timeregs.sv
module sercal_timeregs
  import sercal_pkg::*;
#(
  parameter int TIME_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TIME_W-1:0] sec,
  input  logic [TIME_W-1:0] min,
  input  logic [TIME_W-1:0] hour,
  input  logic [TIME_W-1:0] day,
  input  logic [TIME_W-1:0] mon,
  input  logic [TIME_W-1:0] year,
  input  logic [3:0]        sel,
  output logic [7:0]        q
);

  logic [7:0] b_sec, b_min, b_hour, b_day, b_mon, b_year;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sec  <= '0;
      b_min  <= '0;
      b_hour <= '0;
      b_day  <= '0;
      b_mon  <= '0;
      b_year <= '0;
    end else if (load) begin
      b_sec  <= to_bcd(7'(sec));
      b_min  <= to_bcd(7'(min));
      b_hour <= to_bcd(7'(hour));
      b_day  <= to_bcd(7'(day));
      b_mon  <= to_bcd(7'(mon));
      b_year <= to_bcd(7'(year));
    end
  end

  always_comb begin
    case (sel)
      4'h0:    q = b_sec;
      4'h1:    q = b_min;
      4'h2:    q = b_hour;
      4'h4:    q = b_day;
      4'h5:    q = b_mon;
      4'h6:    q = b_year;
      default: q = 8'h00;
    endcase
  end

  // R7: captured time only moves on a load strobe
  p_time_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(b_sec) && $stable(b_year));

endmodule

// File: rtl/sercal_top.sv
module sercal_top
  import sercal_pkg::*;
#(
  parameter int TIME_W = 7,
  parameter logic [7:0] STATUS_INIT = 8'h90,
  parameter logic [7:0] CTRL_INIT   = 8'h24,
  parameter logic [RAM_BYTES*8-1:0] RAM_INIT = default_image(),
  localparam int FRAME_BITS = 16,
  localparam int CW = $clog2(FRAME_BITS + 1),
  localparam int AW = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_dout_oe,
  input  logic              time_load,
  input  logic [TIME_W-1:0] t_sec,
  input  logic [TIME_W-1:0] t_min,
  input  logic [TIME_W-1:0] t_hour,
  input  logic [TIME_W-1:0] t_day,
  input  logic [TIME_W-1:0] t_mon,
  input  logic [TIME_W-1:0] t_year,
  input  logic              pf_event,
  output logic              pf_irq
);

  localparam logic [7:0] PF_BITS = 8'h18;
  localparam logic [7:0] PF_SET  = 8'h08;

  logic [CW-1:0] bit_cnt;
  logic [7:0]    cmd;
  logic          take;
  logic          frame_done;
  logic [7:0]    data_final;
  cmd_kind_e     kind;
  logic [7:0]    ram_q;
  logic [7:0]    time_q;
  logic [7:0]    rd_byte;
  logic [7:0]    status_q;
  logic          pf_q;
  logic          dout_q;
  logic          oe_q;

  // named events for the checks below
  logic in_data_phase;
  logic bit_out_evt;
  logic ram_wr_hit;
  logic clr_hit;

  sercal_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_en     (ser_en),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .bit_cnt    (bit_cnt),
    .cmd        (cmd),
    .take       (take),
    .frame_done (frame_done),
    .data_final (data_final)
  );

  assign kind          = classify(cmd);
  assign in_data_phase = (bit_cnt >= CW'(FRAME_BITS / 2)) && (bit_cnt < CW'(FRAME_BITS));
  assign bit_out_evt   = take && in_data_phase && is_read_kind(kind);
  assign ram_wr_hit    = frame_done && (kind == K_RAM_WR);
  assign clr_hit       = frame_done && (kind == K_FLAG_CLR) && data_final[2];

  sercal_nvram #(.DEPTH(RAM_BYTES), .IMAGE(RAM_INIT)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ram_wr_hit),
    .wr_addr (cmd[AW-1:0]),
    .wr_data (data_final),
    .rd_addr (cmd[AW-1:0]),
    .rd_data (ram_q)
  );

  sercal_timeregs #(.TIME_W(TIME_W)) u_time (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (time_load),
    .sec   (t_sec),
    .min   (t_min),
    .hour  (t_hour),
    .day   (t_day),
    .mon   (t_mon),
    .year  (t_year),
    .sel   (cmd[3:0]),
    .q     (time_q)
  );

  always_comb begin
    case (kind)
      K_RAM_RD: rd_byte = ram_q;
      K_TIME:   rd_byte = time_q;
      K_STAT:   rd_byte = status_q;
      K_CTRL:   rd_byte = CTRL_INIT;
      default:  rd_byte = 8'h00;
    endcase
  end

  // status and power-fail flag: a new event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STATUS_INIT;
      pf_q     <= 1'b0;
    end else begin
      if (pf_event) begin
        status_q <= (clr_hit ? (status_q & ~PF_BITS) : status_q) | PF_SET;
        pf_q     <= 1'b1;
      end else if (clr_hit) begin
        status_q <= status_q & ~PF_BITS;
        pf_q     <= 1'b0;
      end
    end
  end

  // read data return: bit 7-(p-8) after the edge of position p
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (!ser_en) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (bit_out_evt) begin
      dout_q <= rd_byte[~bit_cnt[2:0]];
      oe_q   <= 1'b1;
    end
  end

  assign ser_dout    = dout_q;
  assign ser_dout_oe = oe_q;
  assign pf_irq      = pf_q;

  // R12: pad released after enable drops
  p_oe_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> (!ser_dout_oe && !ser_dout));

  // R8: flag only rises after an event
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_irq) |-> $past(pf_event));

  // R9: flag only falls after a qualifying clear frame
  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pf_irq) |-> $past(clr_hit));

  // R4: RAM writes happen only on a completed frame
  p_wr_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_hit |=> bit_cnt == CW'(FRAME_BITS));

  // R12: read pad never driven for a non-read command
  p_oe_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && bit_cnt != '0 && !is_read_kind(kind)) |-> !ser_dout_oe);

endmodule

// File: tb/sim_sercal_top.sv
module sim_sercal_top;

  localparam logic [7:0] CTRL_V = 8'h6B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_dout_oe, pf_irq;
  logic time_load = 1'b0, pf_event = 1'b0;
  logic [6:0] t_sec = '0, t_min = '0, t_hour = '0, t_day = '0, t_mon = '0, t_year = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  // scoreboard queues
  int    exp_q[$];
  string tag_q[$];
  int    got_q[$];

  int ram_m [32];

  always #10 clk = ~clk;

  sercal_top #(.CTRL_INIT(CTRL_V)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe), .time_load(time_load),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_day(t_day), .t_mon(t_mon),
    .t_year(t_year), .pf_event(pf_event), .pf_irq(pf_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  task automatic sbit(input logic b);
    @(negedge clk);
    ser_din = b;
    ser_clk = 1'b1;
    repeat (2) @(negedge clk);
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Runs one frame of nbits; bits past 16 carry the inverted data byte.
  task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nbits,
                      output logic [7:0] rd, output logic oe_seen);
    logic b;
    rd = '0;
    oe_seen = 1'b0;
    @(negedge clk);
    ser_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i < 8)       b = c[7 - i];
      else if (i < 16) b = d[15 - i];
      else             b = ~d[23 - i];
      sbit(b);
      if (i >= 8 && i < 16) begin
        rd = {rd[6:0], ser_dout};
        oe_seen = oe_seen | ser_dout_oe;
      end
    end
    ser_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // driver: push expectation, run read frame, push result
  task automatic rd_check(input logic [7:0] c, input int exp, input string tag);
    logic [7:0] rd;
    logic oe;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(c, 8'h00, 16, rd, oe);
    got_q.push_back(int'(rd));
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d, input int nbits);
    logic [7:0] rd;
    logic oe;
    xfer(c, d, nbits, rd, oe);
  endtask

  // monitor: compare results in order
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    for (int i = 0; i < 32; i++) ram_m[i] = ((i * 17) & 255) ^ 165;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    check("R12 reset oe", int'(ser_dout_oe), 0);
    check("R8 reset pf_irq", int'(pf_irq), 0);

    // R11 / R3: reset image via reads, oe seen during read
    rd_check(8'h00, ram_m[0], "R11 ram0");
    rd_check(8'h05, ram_m[5], "R11 ram5");
    rd_check(8'h1F, ram_m[31], "R3 ram31");
    xfer(8'h0A, 8'h00, 16, rd, oe);
    check("R3 read data", int'(rd), ram_m[10]);
    check("R3 oe driven", int'(oe), 1);

    // R4: write then read
    xfer(8'h85, 8'h3C, 16, rd, oe);
    check("R12 oe idle on write", int'(oe), 0);
    rd_check(8'h05, 8'h3C, "R4 write ram5");

    // R10: extra bits after the frame must not rewrite
    wr(8'h9F, 8'hC3, 24);
    rd_check(8'h1F, 8'hC3, "R10 saturated write");

    // R2: abort after 12 bits leaves RAM alone
    wr(8'h83, 8'h11, 12);
    rd_check(8'h03, ram_m[3], "R2 aborted write");

    // R1: stray edges with enable low are ignored
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ser_din = 1'b1; ser_clk = 1'b1;
      repeat (2) @(negedge clk); ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    rd_check(8'h30, 8'h90, "R1 R5 status after stray edges");
    rd_check(8'h31, int'(CTRL_V), "R5 control");

    // R6 / R7: time
    t_sec = 7'd59; t_min = 7'd7; t_hour = 7'd23; t_day = 7'd31; t_mon = 7'd12; t_year = 7'd99;
    @(negedge clk); time_load = 1'b1; @(negedge clk); time_load = 1'b0;
    rd_check(8'h20, bcd(59), "R6 sec");
    rd_check(8'h21, bcd(7), "R6 min");
    rd_check(8'h22, bcd(23), "R6 hour");
    rd_check(8'h23, 0, "R6 unused 0x23");
    rd_check(8'h24, bcd(31), "R6 day");
    rd_check(8'h25, bcd(12), "R6 month");
    rd_check(8'h26, bcd(99), "R6 year");
    rd_check(8'h2F, 0, "R6 unused 0x2F");
    t_sec = 7'd12;
    repeat (3) @(negedge clk);
    rd_check(8'h20, bcd(59), "R7 no load holds");
    @(negedge clk); time_load = 1'b1; @(negedge clk); time_load = 1'b0;
    rd_check(8'h20, bcd(12), "R7 reload");

    // R8 / R9: power-fail flag
    @(negedge clk); pf_event = 1'b1; @(negedge clk); pf_event = 1'b0;
    @(negedge clk);
    check("R8 pf_irq set", int'(pf_irq), 1);
    rd_check(8'h30, 8'h98, "R8 status bit3");
    wr(8'hB1, 8'h00, 16);
    check("R9 no clear without bit2", int'(pf_irq), 1);
    rd_check(8'h30, 8'h98, "R9 status kept");
    wr(8'hB1, 8'h04, 16);
    check("R9 pf_irq cleared", int'(pf_irq), 0);
    rd_check(8'h30, 8'h80, "R9 status cleared");

    // R12: unsupported command never drives
    xfer(8'h40, 8'h00, 16, rd, oe);
    check("R12 oe for 0x40", int'(oe), 0);
    check("R12 dout for 0x40", int'(rd), 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule